// File: doc/BRIEF.md
# Fractional Parity Post-Encoder for a Three-Dimensional Turbo Encoder

This block sits behind the two constituent encoders of a turbo encoder. Each input beat carries one bit from each of the two parity streams of the current frame. The block keeps a configurable share of these parity bits (one in four or one in eight) on a fixed pattern that alternates between the two streams, and stores them in an internal frame buffer. Once the frame has been loaded, it reads the buffer back in a regular permuted order: each address is the previous address plus a fixed step, modulo the number of stored bits. The bits it reads feed a four-state recursive accumulator code of rate one. The output is a third parity stream, and the encoder state at the end of the frame equals the state at its start.

The accumulator has feedback polynomial 1+D+D². Its output is the recursive bit itself. This recursion has a state period of three, so the circulation state can be found in closed form from the zero-start end state whenever the stored length N is not a multiple of three. Encoding therefore takes two silent-then-emitting passes over the buffer. While the block works on a frame it holds the input not ready. It takes the next frame only when the current frame's last output bit leaves.

Top module: `parity_post_encoder`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: With K input pairs per frame, H is 2 when `cfg_eighth`=0 and 4 when `cfg_eighth`=1. The pair with index j (0-based) is kept when j mod H = 0. It is taken from `in_p1` when j/H is even and from `in_p2` when j/H is odd. This gives N = K/H stored bits, and K must be a multiple of H.
- R3: Stored bits are encoded in the order of buffer address (P·i + s) mod N for i = 0..N−1. Here P is `cfg_step` and s is `cfg_start`, with P coprime to N, P < N and s < N.
- R4: The encoder state is (a, b). For input x it emits r = x ⊕ a ⊕ b and moves to state (r, a). The stream on `out_bit` is the sequence of r values.
- R5: For every frame with N not a multiple of 3, the state before the first emitted bit equals the state after the last emitted bit.
- R6: Each frame produces exactly N consecutive beats with `out_valid`=1. `out_last` is 1 only on the Nth beat, and the cycle after it has `out_valid`=0.
- R7: `in_ready` is 0 from the cycle after the last input beat of a frame until the cycle of that frame's `out_last`, and is 1 in that cycle. While idle, a beat without `in_sof` is dropped.
- R8: The configuration inputs are sampled only on the accepted `in_sof` beat. Later changes have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_eighth | input | 1 | 0 keeps one parity bit in four, 1 keeps one in eight |
| cfg_pairs | input | AW+3 | Parity pairs per frame (K) |
| cfg_step | input | AW+1 | Permutation step P |
| cfg_start | input | AW+1 | Permutation start offset s |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can accept a beat |
| in_sof | input | 1 | First beat of a frame |
| in_p1 | input | 1 | Bit of parity stream 1 |
| in_p2 | input | 1 | Bit of parity stream 2 |
| out_valid | output | 1 | Post-encoded bit valid |
| out_bit | output | 1 | Post-encoded parity bit |
| out_last | output | 1 | Final bit of the frame |

## Verification
Two things can happen in the same cycle: the last output bit of one frame leaves, and the start-of-frame beat of the next frame is accepted. The bench queues the second frame's first beat with valid held high while the first frame is still being encoded. This makes the handshake complete in exactly the `out_last` cycle. The bench then checks two things: that `in_ready`, `in_valid` and `in_sof` are all high in that cycle, and that both frames come out bit-exact against an independently computed model, with the state restored at each frame's end.

// File: rtl/parity_post_encoder.sv
module parity_post_encoder #(
  parameter int MAXN = 256
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_eighth,
  input  logic [$clog2(MAXN)+2:0]   cfg_pairs,
  input  logic [$clog2(MAXN):0]     cfg_step,
  input  logic [$clog2(MAXN):0]     cfg_start,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic                      in_sof,
  input  logic                      in_p1,
  input  logic                      in_p2,
  output logic                      out_valid,
  output logic                      out_bit,
  output logic                      out_last
);
  localparam int AW = $clog2(MAXN);
  localparam int KW = AW + 3;

  typedef enum logic [1:0] {IDLE = 2'd0, LOAD = 2'd1, RUN1 = 2'd2, RUN2 = 2'd3} ph_t;

  ph_t            ph;
  logic [MAXN-1:0] mem;
  logic [KW-1:0]  j, k_q;
  logic           eighth_q;
  logic [AW:0]    w, step_q, start_q, rd, i;
  logic [1:0]     m3, st;

  assign in_ready = (ph == IDLE) || (ph == LOAD);
  wire take = in_valid && in_ready;

  wire keep  = eighth_q ? (j[1:0] == 2'd0) : (j[0] == 1'b0);
  wire pick2 = eighth_q ? j[2] : j[1];

  wire       x   = mem[rd[AW-1:0]];
  wire       r   = x ^ st[1] ^ st[0];
  wire [1:0] nst = {r, st[1]};

  wire [AW+1:0] sum  = {1'b0, rd} + {1'b0, step_q};
  wire [AW+1:0] diff = sum - {1'b0, w};
  wire [AW:0]   rd_nx = (sum >= {1'b0, w}) ? diff[AW:0] : sum[AW:0];

  wire [1:0] circ = (m3 == 2'd1) ? {nst[1] ^ nst[0], nst[1]}
                                 : {nst[0], nst[1] ^ nst[0]};
  wire last_i = (i == w - 1'b1);

  always_ff @(posedge clk) begin
    if (take) begin
      if (ph == IDLE && in_sof) mem[0] <= in_p1;
      else if (ph == LOAD && keep) mem[w[AW-1:0]] <= pick2 ? in_p2 : in_p1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= IDLE;
      j <= '0; k_q <= '0; eighth_q <= 1'b0;
      w <= '0; step_q <= '0; start_q <= '0; rd <= '0; i <= '0;
      m3 <= '0; st <= '0;
      out_valid <= 1'b0; out_bit <= 1'b0; out_last <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      case (ph)
        IDLE: if (take && in_sof) begin
          k_q <= cfg_pairs; eighth_q <= cfg_eighth;
          step_q <= cfg_step; start_q <= cfg_start;
          j <= KW'(1); w <= (AW+1)'(1); m3 <= 2'd1;
          ph <= LOAD;
        end
        LOAD: if (take) begin
          j <= j + 1'b1;
          if (keep) begin
            w  <= w + 1'b1;
            m3 <= (m3 == 2'd2) ? 2'd0 : m3 + 2'd1;
          end
          if (j == k_q - 1'b1) begin
            ph <= RUN1; i <= '0; st <= 2'd0; rd <= start_q;
          end
        end
        RUN1: begin
          st <= nst; rd <= rd_nx; i <= i + 1'b1;
          if (last_i) begin
            ph <= RUN2; st <= circ; rd <= start_q; i <= '0;
          end
        end
        RUN2: begin
          out_valid <= 1'b1; out_bit <= r; out_last <= last_i;
          st <= nst; rd <= rd_nx; i <= i + 1'b1;
          if (last_i) ph <= IDLE;
        end
        default: ph <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ppe_checks.sv
module ppe_checks #(
  parameter int MAXN = 256
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_ready,
  input logic                  out_valid,
  input logic                  out_last,
  input logic [1:0]            ph,
  input logic [1:0]            st,
  input logic [$clog2(MAXN):0] w
);
  localparam int AW = $clog2(MAXN);
  logic [AW:0] cnt;
  logic [1:0]  st0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; st0 <= '0;
    end else begin
      if (out_last) cnt <= '0;
      else if (out_valid) cnt <= cnt + 1'b1;
      if (ph == 2'd3 && !out_valid) st0 <= st;
    end
  end

  p_busy_not_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_last |-> !in_ready);
  p_ready_at_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> in_ready);
  p_last_is_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
  p_gap_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> !out_valid);
  p_beat_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (cnt + 1'b1 == w));
  p_state_wraps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (st == st0));
endmodule

bind parity_post_encoder ppe_checks #(.MAXN(MAXN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_last(out_last), .ph(ph), .st(st), .w(w)
);

// File: tb/parity_post_encoder_bench.sv
`timescale 1ns/1ps
module parity_post_encoder_bench;
  localparam int MAXN = 256;
  localparam int AW = $clog2(MAXN);

  logic clk = 0, rst_n = 0;
  logic cfg_eighth = 0;
  logic [AW+2:0] cfg_pairs = '0;
  logic [AW:0] cfg_step = '0, cfg_start = '0;
  logic in_valid = 0, in_sof = 0, in_p1 = 0, in_p2 = 0;
  logic in_ready, out_valid, out_bit, out_last;

  always #2 clk = ~clk;

  parity_post_encoder #(.MAXN(MAXN)) u_parity_post_encoder (
    .clk(clk), .rst_n(rst_n), .cfg_eighth(cfg_eighth), .cfg_pairs(cfg_pairs),
    .cfg_step(cfg_step), .cfg_start(cfg_start), .in_valid(in_valid),
    .in_ready(in_ready), .in_sof(in_sof), .in_p1(in_p1), .in_p2(in_p2),
    .out_valid(out_valid), .out_bit(out_bit), .out_last(out_last));

  int n_chk = 0, n_fail = 0;
  bit sp1 [0:1][0:2047];
  bit sp2 [0:1][0:2047];
  bit px  [0:1][0:1023];
  bit ex  [0:1][0:1023];
  int en [0:1], ek [0:1], ep [0:1], es [0:1];
  bit eh [0:1];

  task automatic chk(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic prep(int sl, int k, bit eighth, int p, int s, logic [15:0] seed);
    logic [15:0] lf = seed;
    int h, n;
    bit sel [0:1023];
    bit [1:0] c, stt;
    h = eighth ? 4 : 2;
    n = k / h;
    for (int q = 0; q < k; q++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      sp1[sl][q] = lf[0];
      sp2[sl][q] = lf[5];
    end
    for (int m = 0; m < n; m++) sel[m] = (m % 2 == 0) ? sp1[sl][m*h] : sp2[sl][m*h];
    for (int q = 0; q < n; q++) px[sl][q] = sel[(p*q + s) % n];
    c = 2'd0;
    for (int cc = 0; cc < 4; cc++) begin
      stt = 2'(cc);
      for (int q = 0; q < n; q++) stt = {px[sl][q] ^ stt[1] ^ stt[0], stt[1]};
      if (stt == 2'(cc)) c = 2'(cc);
    end
    stt = c;
    for (int q = 0; q < n; q++) begin
      ex[sl][q] = px[sl][q] ^ stt[1] ^ stt[0];
      stt = {ex[sl][q], stt[1]};
    end
    en[sl] = n; ek[sl] = k; ep[sl] = p; es[sl] = s; eh[sl] = eighth;
  endtask

  task automatic beat(bit sof, bit a, bit b);
    in_valid = 1; in_sof = sof; in_p1 = a; in_p2 = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic drive(int sl, bit junk);
    if (junk) beat(0, 1, 1);
    cfg_eighth = eh[sl]; cfg_pairs = (AW+3)'(ek[sl]);
    cfg_step = (AW+1)'(ep[sl]); cfg_start = (AW+1)'(es[sl]);
    for (int q = 0; q < ek[sl]; q++) begin
      beat(q == 0, sp1[sl][q], sp2[sl][q]);
      if (junk && q == 0) begin
        cfg_eighth = ~eh[sl]; cfg_pairs = (AW+3)'(4);
        cfg_step = (AW+1)'(1); cfg_start = '0;
      end
    end
    in_valid = 0; in_sof = 0;
  endtask

  task automatic collect(int sl, string req, bit b2b);
    int guard = 0, n;
    bit got [0:1023];
    bit a, b;
    n = en[sl];
    while (!out_valid && guard < 5000) begin @(negedge clk); guard++; end
    if (guard >= 5000) begin chk(0, req, "no output", 0, 1); return; end
    for (int q = 0; q < n; q++) begin
      chk(out_valid == 1'b1, "R6", "valid run", int'(out_valid), 1);
      chk(out_bit == ex[sl][q], req, $sformatf("bit %0d", q), int'(out_bit), int'(ex[sl][q]));
      chk(out_last == (q == n-1), "R6", $sformatf("last flag at %0d", q), int'(out_last), int'(q == n-1));
      got[q] = out_bit;
      if (q < n-1) chk(in_ready == 1'b0, "R7", "ready while busy", int'(in_ready), 0);
      else if (b2b) chk(in_ready && in_valid && in_sof, "R7", "next sof taken with last", int'(in_ready && in_valid && in_sof), 1);
      @(negedge clk);
    end
    chk(out_valid == 1'b0, "R6", "gap after last", int'(out_valid), 0);
    a = px[sl][1] ^ got[0] ^ got[1];
    b = got[0] ^ px[sl][0] ^ a;
    chk({a, b} == {got[n-1], got[n-2]}, "R5", "start vs end state", int'({a, b}), int'({got[n-1], got[n-2]}));
  endtask

  task automatic t_reset();
    chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_quarter();
    prep(0, 40, 0, 3, 0, 16'hACE1);
    fork drive(0, 0); collect(0, "R2 R4", 0); join
  endtask

  task automatic t_eighth();
    prep(0, 64, 1, 5, 3, 16'h1234);
    fork drive(0, 0); collect(0, "R2 R4", 0); join
  endtask

  task automatic t_perm();
    prep(0, 200, 0, 37, 11, 16'hBEEF);
    fork drive(0, 0); collect(0, "R3", 0); join
  endtask

  task automatic t_junk_cfg();
    prep(0, 20, 0, 3, 2, 16'h0F0F);
    fork drive(0, 1); collect(0, "R7 R8", 0); join
  endtask

  task automatic t_back_to_back();
    prep(0, 44, 0, 5, 7, 16'h5A5A);
    prep(1, 80, 1, 7, 4, 16'h3C3C);
    fork
      begin drive(0, 0); drive(1, 0); end
      begin collect(0, "R7", 1); collect(1, "R2 R3", 0); end
    join
  endtask

  initial begin
    #400000;
    chk(0, "ALL", "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_quarter();
    t_eighth();
    t_perm();
    t_junk_cfg();
    t_back_to_back();
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule